// File: doc/BRIEF.md
# Transmit Staging and Empty-Flag Logic

This block sits in a serial transmitter between the processor's data-register write port and the bit serializer. It takes each byte the processor writes and decides where it goes. If the shifter is free and nothing is waiting, the byte goes straight to the shifter. If the shifter is busy, the byte waits in a staging store. The store is either an 8-entry FIFO or, with the FIFO switched off, a single holding slot. Each time the serializer reports that the last bit of a byte has left the line, the oldest waiting byte is handed to the shifter as a parallel load.

The block keeps two status flags. Buffer-empty means nothing is waiting in the staging store. Shifter-empty means the serializer has no byte to send. The rules are asymmetric. A write into an idle path loads the shifter and leaves buffer-empty set. A transfer from the store into the shifter leaves shifter-empty clear. Shifter-empty rises only when the serializer finishes and nothing is waiting. Each flag drives an interrupt request gated by its own enable. A write that finds the store full is discarded and latches a sticky overrun indication.

Top module: `txs_stage`

## Requirements
- R1: After reset, buf_empty and shf_empty are 1; buf_irq, shf_irq, overrun and ld_valid are 0.
- R2: A write accepted while nothing is staged and the shifter is free produces, one cycle later, ld_valid=1 with ld_data equal to the written byte, shf_empty=0 and buf_empty still 1. The shifter counts as free when shf_empty=1, or when shift_done is high in the same cycle.
- R3: A write while the shifter is busy (shf_empty=0 and no shift_done) is stored. One cycle later buf_empty=0, shf_empty stays 0 and no load is issued.
- R4: When the shifter becomes free while bytes are staged, the oldest staged byte is loaded one cycle later (ld_valid=1), in write order, and shf_empty stays 0.
- R5: buf_empty returns to 1 only in the cycle after the last staged byte is moved into the shifter.
- R6: A shift_done pulse with nothing staged and no write clears the shifter: one cycle later shf_empty=1 and ld_valid=0.
- R7: The staging store holds 8 bytes when fifo_en=1 and 1 byte when fifo_en=0.
- R8: A write that is not loaded directly and finds the store full, with no transfer freeing a slot in the same cycle, is discarded. overrun then becomes 1 and stays 1 until reset.
- R9: buf_irq and shf_irq equal buf_empty AND buf_irq_en and shf_empty AND shf_irq_en. The enables are sampled at the clock edge that updates the flag.
- R10: A shift_done pulse while shf_empty=1 and no write has no effect: no load, and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe to the transmit data register |
| wr_data | input | 8 | Byte being written |
| fifo_en | input | 1 | 1 selects the 8-entry FIFO, 0 the single holding slot |
| shift_done | input | 1 | Pulse from the serializer: the final bit has left the line |
| buf_irq_en | input | 1 | Enable for the buffer-empty interrupt |
| shf_irq_en | input | 1 | Enable for the shifter-empty interrupt |
| ld_valid | output | 1 | Parallel-load strobe to the shifter |
| ld_data | output | 8 | Byte to load into the shifter |
| buf_empty | output | 1 | Nothing staged |
| shf_empty | output | 1 | Shifter holds no byte |
| buf_irq | output | 1 | Buffer-empty interrupt request |
| shf_irq | output | 1 | Shifter-empty interrupt request |
| overrun | output | 1 | Sticky: a write was discarded because the store was full |

## Verification
Two conditions are the hardest to reach from the ports.

The first is a write that lands in the same cycle as shift_done while exactly one byte is staged. The pop and the push then overlap, and buf_empty must stay clear. The second is a mode switch to the holding slot while several bytes are already queued in the FIFO.

The random phase drives shift_done often and writes at a similar rate, so the queue length drifts around small values where these overlaps occur. It also flips fifo_en at random with bytes in flight. Directed steps first fill the FIFO to its limit and push one write past it, then check the single-slot capacity.

// File: rtl/txs_pkg.sv
`timescale 1ns/1ps
package txs_pkg;
  localparam int unsigned TXS_DATA_W = 8;
  localparam int unsigned TXS_DEPTH  = 8;

  typedef enum logic [0:0] {
    IRQ_SRC_BUF = 1'b0,
    IRQ_SRC_SHF = 1'b1
  } irq_src_e;

  localparam int unsigned TXS_IRQ_N = 2;
endpackage

// File: rtl/txs_fifo.sv
`timescale 1ns/1ps
module txs_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count_nxt
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap;

  // Capacity follows the mode: full depth, or one slot as a holding register.
  assign cap   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign empty = (count == '0);
  assign full  = (count >= cap);
  assign head  = mem[rd_ptr];

  assign count_nxt = count + CNT_W'(push) - CNT_W'(pop);

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + ADDR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST_ADDR) ? '0 : rd_ptr + ADDR_W'(1);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/txs_ctrl.sv
`timescale 1ns/1ps
module txs_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              shift_done,
  input  logic [DATA_W-1:0] q_head,
  input  logic              q_empty,
  input  logic              q_full,
  input  logic [CNT_W-1:0]  q_count_nxt,
  output logic              q_push,
  output logic              q_pop,
  output logic              buf_empty_d,
  output logic              shf_empty_d,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              buf_empty,
  output logic              shf_empty,
  output logic              overrun
);
  logic free;
  logic direct;
  logic drop;
  logic busy_d;

  // The shifter can take a byte if it is idle or finishing this cycle.
  assign free   = shf_empty | shift_done;
  assign q_pop  = free & ~q_empty;
  assign direct = free & q_empty & wr_en;
  assign q_push = wr_en & ~direct & (~q_full | q_pop);
  assign drop   = wr_en & ~direct & q_full & ~q_pop;

  assign busy_d      = free ? (q_pop | direct) : 1'b1;
  assign shf_empty_d = ~busy_d;
  assign buf_empty_d = (q_count_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      buf_empty <= 1'b1;
      shf_empty <= 1'b1;
      overrun   <= 1'b0;
    end else begin
      ld_valid  <= q_pop | direct;
      if (q_pop)       ld_data <= q_head;
      else if (direct) ld_data <= wr_data;
      buf_empty <= buf_empty_d;
      shf_empty <= shf_empty_d;
      if (drop) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/txs_irq.sv
`timescale 1ns/1ps
module txs_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_d,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] irq
);
  // One registered request per source, updated on the same edge as its flag.
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) irq[i] <= 1'b0;
      else     irq[i] <= flag_d[i] & irq_en[i];
    end
  end
endmodule

// File: rtl/txs_stage.sv
`timescale 1ns/1ps
module txs_stage
  import txs_pkg::*;
#(
  parameter int unsigned DATA_W = TXS_DATA_W,
  parameter int unsigned DEPTH  = TXS_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_en,
  input  logic              shift_done,
  input  logic              buf_irq_en,
  input  logic              shf_irq_en,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              buf_empty,
  output logic              shf_empty,
  output logic              buf_irq,
  output logic              shf_irq,
  output logic              overrun
);
  logic              q_push, q_pop, q_empty, q_full;
  logic [DATA_W-1:0] q_head;
  logic [CNT_W-1:0]  q_count_nxt;
  logic              buf_empty_d, shf_empty_d;
  logic [TXS_IRQ_N-1:0] flag_d, irq_en, irq;

  txs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (fifo_en),
    .push      (q_push),
    .pop       (q_pop),
    .din       (wr_data),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full),
    .count_nxt (q_count_nxt)
  );

  txs_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .shift_done  (shift_done),
    .q_head      (q_head),
    .q_empty     (q_empty),
    .q_full      (q_full),
    .q_count_nxt (q_count_nxt),
    .q_push      (q_push),
    .q_pop       (q_pop),
    .buf_empty_d (buf_empty_d),
    .shf_empty_d (shf_empty_d),
    .ld_valid    (ld_valid),
    .ld_data     (ld_data),
    .buf_empty   (buf_empty),
    .shf_empty   (shf_empty),
    .overrun     (overrun)
  );

  assign flag_d[IRQ_SRC_BUF] = buf_empty_d;
  assign flag_d[IRQ_SRC_SHF] = shf_empty_d;
  assign irq_en[IRQ_SRC_BUF] = buf_irq_en;
  assign irq_en[IRQ_SRC_SHF] = shf_irq_en;

  txs_irq #(.N(TXS_IRQ_N)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flag_d (flag_d),
    .irq_en (irq_en),
    .irq    (irq)
  );

  assign buf_irq = irq[IRQ_SRC_BUF];
  assign shf_irq = irq[IRQ_SRC_SHF];
endmodule

// File: rtl/txs_checker.sv
`timescale 1ns/1ps
module txs_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              shift_done,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data,
  input logic              buf_empty,
  input logic              shf_empty,
  input logic              buf_irq,
  input logic              shf_irq,
  input logic              overrun
);
  assert_direct_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && buf_empty && shf_empty) |=>
      (ld_valid && ld_data == $past(wr_data) && buf_empty && !shf_empty));

  assert_busy_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && buf_empty && !shf_empty && !shift_done) |=>
      (!buf_empty && !shf_empty && !ld_valid));

  assert_refill_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_done && !shf_empty && !buf_empty) |=> (ld_valid && !shf_empty));

  assert_load_when_free_R4: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(shf_empty || shift_done));

  assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
    (shift_done && buf_empty && !wr_en) |=> (shf_empty && !ld_valid));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_buf_irq_R9: assert property (@(posedge clk) disable iff (rst)
    buf_irq |-> buf_empty);

  assert_shf_irq_R9: assert property (@(posedge clk) disable iff (rst)
    shf_irq |-> shf_empty);
endmodule

bind txs_stage txs_checker #(.DATA_W(DATA_W)) u_txs_checker (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .shift_done (shift_done),
  .ld_valid   (ld_valid),
  .ld_data    (ld_data),
  .buf_empty  (buf_empty),
  .shf_empty  (shf_empty),
  .buf_irq    (buf_irq),
  .shf_irq    (shf_irq),
  .overrun    (overrun)
);

// File: tb/txs_stage_bench.sv
`timescale 1ns/1ps
module txs_stage_bench;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, fifo_en, shift_done, buf_irq_en, shf_irq_en;
  logic [7:0] wr_data;
  logic       ld_valid, buf_empty, shf_empty, buf_irq, shf_irq, overrun;
  logic [7:0] ld_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // Reference model state
  logic [7:0] mq [DEPTH];
  int   mcount;
  bit   mbusy, movr, mldv, mbirq, msirq;
  logic [7:0] mldd;

  always #5 clk = ~clk;

  txs_stage u_txs_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_en(fifo_en), .shift_done(shift_done),
    .buf_irq_en(buf_irq_en), .shf_irq_en(shf_irq_en),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .buf_empty(buf_empty), .shf_empty(shf_empty),
    .buf_irq(buf_irq), .shf_irq(shf_irq), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cap_of(input bit fen);
    return fen ? DEPTH : 1;
  endfunction

  task automatic model_reset();
    mcount = 0; mbusy = 0; movr = 0; mldv = 0; mldd = 8'h00;
    mbirq = 0; msirq = 0;
  endtask

  // Expected next state from the requirements, given the inputs at this edge.
  task automatic model_step();
    bit free, popped;
    popped = 0;
    free = !mbusy || shift_done;
    mldv = 0;
    if (free) begin
      if (mcount > 0) begin
        mldd = mq[0];
        for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
        mcount--; mldv = 1; mbusy = 1; popped = 1;
        if (wr_en) begin
          if (mcount + 1 < cap_of(fifo_en) || popped) begin mq[mcount] = wr_data; mcount++; end
          else movr = 1;
        end
      end else if (wr_en) begin
        mldd = wr_data; mldv = 1; mbusy = 1;
      end else begin
        mbusy = 0;
      end
    end else if (wr_en) begin
      if (mcount < cap_of(fifo_en)) begin mq[mcount] = wr_data; mcount++; end
      else movr = 1;
    end
    mbirq = (mcount == 0) && buf_irq_en;
    msirq = !mbusy && shf_irq_en;
  endtask

  task automatic compare_all();
    chk("R4", "ld_valid", ld_valid, mldv);
    if (mldv) chk("R4", "ld_data", ld_data, mldd);
    chk("R5", "buf_empty", buf_empty, mcount == 0);
    chk("R6", "shf_empty", shf_empty, !mbusy);
    chk("R9", "buf_irq", buf_irq, mbirq);
    chk("R9", "shf_irq", shf_irq, msirq);
    chk("R8", "overrun", overrun, movr);
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input bit sd, input bit fen);
    wr_en = w; wr_data = d; shift_done = sd; fifo_en = fen;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; wr_data = 0; shift_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1", "buf_empty", buf_empty, 1);
    chk("R1", "shf_empty", shf_empty, 1);
    chk("R1", "buf_irq", buf_irq, 0);
    chk("R1", "shf_irq", shf_irq, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "ld_valid", ld_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fifo_en = 1; buf_irq_en = 1; shf_irq_en = 1;
    wr_en = 0; wr_data = 0; shift_done = 0;
    @(negedge clk);
    do_reset();

    // R10: serializer pulse while idle changes nothing
    cyc(0, 8'h00, 1, 1);
    chk("R10", "ld_valid", ld_valid, 0);
    chk("R10", "shf_empty", shf_empty, 1);
    chk("R10", "buf_empty", buf_empty, 1);

    // R2: write into idle path loads directly
    cyc(1, 8'hA5, 0, 1);
    chk("R2", "ld_valid", ld_valid, 1);
    chk("R2", "ld_data", ld_data, 8'hA5);
    chk("R2", "buf_empty", buf_empty, 1);
    chk("R2", "shf_empty", shf_empty, 0);

    // R3: write while busy is staged
    cyc(1, 8'h10, 0, 1);
    chk("R3", "buf_empty", buf_empty, 0);
    chk("R3", "shf_empty", shf_empty, 0);
    chk("R3", "ld_valid", ld_valid, 0);

    // R7: fill to eight entries, then one more is dropped (R8)
    for (int i = 1; i < DEPTH; i++) cyc(1, 8'(8'h10 + i), 0, 1);
    chk("R7", "overrun_at_8", overrun, 0);
    cyc(1, 8'hEE, 0, 1);
    chk("R8", "overrun_set", overrun, 1);

    // R4/R5: drain in order; buf_empty rises only after the last transfer
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 8'h00, 1, 1);
      chk("R4", "order", ld_data, 8'(8'h10 + i));
      chk("R5", "buf_empty", buf_empty, (i == DEPTH - 1) ? 1 : 0);
    end
    cyc(0, 8'h00, 1, 1);
    chk("R6", "shf_empty", shf_empty, 1);

    // R7: holding mode keeps a single byte
    do_reset();
    cyc(1, 8'h21, 0, 0);
    cyc(1, 8'h22, 0, 0);
    cyc(1, 8'h23, 0, 0);
    chk("R7", "overrun_hold", overrun, 1);
    cyc(0, 8'h00, 1, 0);
    chk("R7", "hold_data", ld_data, 8'h22);
    cyc(0, 8'h00, 1, 0);
    chk("R7", "hold_drained", shf_empty, 1);

    // Random phase
    do_reset();
    fifo_en = 1;
    for (int n = 0; n < 4000; n++) begin
      bit fen;
      fen = fifo_en;
      if ($urandom_range(99) == 0) fen = !fen;
      if ($urandom_range(19) == 0) buf_irq_en = !buf_irq_en;
      if ($urandom_range(19) == 0) shf_irq_en = !shf_irq_en;
      cyc($urandom_range(99) < 40, 8'($urandom), $urandom_range(99) < 35, fen);
      if ($urandom_range(999) == 0) do_reset();
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule